// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Controller

This controller sits on the host side of one or more serial-output data converters whose serial outputs are cascaded into a single chain. It releases the converters from reset with one clean low pulse. After that it runs a free-running conversion toggle, `conv_o`, derived from the system clock. When the converters signal through the active-low ready line that results are waiting, it produces a gated data clock and shifts the whole chain into the host. The bit count of a readout is the number of devices times the channels per device times the bits per result.

Each completed result is handed out on a parallel bus with a one-cycle strobe and a running channel index. The ready line has an uncertain phase relative to the conversion toggle. For that reason the controller polls the line through a synchronizer instead of timing the readout from the toggle. The data clock stays low whenever no shift is under way. It also pauses low, at a bit boundary, around every edge of the conversion toggle. The first results after a device reset are dropped: the ready edges that belong to them are ignored.

Top module: `adc_chain_reader`

## Requirements
- R1: `dev_rst_n_o` is low while `rst_n` is low and for exactly `RST_CYC` clock edges after `rst_n` rises. After that it stays high until the next `rst_n` assertion.
- R2: `conv_o` is held low while `dev_rst_n_o` is low. Afterwards it toggles every `CONV_CYC` clock cycles.
- R3: After each device reset release, the first `SKIP_CONV` falling edges of `dready_n_i` are ignored. They produce no data-clock edge and no word strobe.
- R4: A readout starts only on a falling edge of `dready_n_i`. It produces exactly `N_DEV*CH_PER_DEV*RES_BITS` rising edges of `dclk_o`, and `dclk_o` then stays low.
- R5: `sdata_i` is captured at each `dclk_o` rising edge, most significant bit first. Every `RES_BITS` bits form one word on `word_o`, marked by a single-cycle `word_valid_o` and a `chan_o` index that counts from 0 in shift order.
- R6: `dclk_o` is low in the clock cycle before and the cycle of every `conv_o` change. It does not rise within `CONV_GUARD` cycles after such a change.
- R7: A falling edge of `dready_n_i` during a readout sets `overrun_o`, which stays set until `rst_n` is asserted. The current readout still completes with its full bit count and correct data.
- R8: Each high phase of `dclk_o` lasts exactly `DCLK_DIV` clock cycles.
- R9: Asserting `rst_n` low takes effect at once, with no clock edge. It forces `dclk_o`, `conv_o`, `word_valid_o`, `overrun_o` and `dev_rst_n_o` low, and a later release restarts the sequence of R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dready_n_i | input | 1 | Active-low data-ready from the converter chain |
| sdata_i | input | 1 | Serial data from the end of the chain |
| conv_o | output | 1 | Conversion toggle |
| dev_rst_n_o | output | 1 | Active-low reset pulse to the converters |
| dclk_o | output | 1 | Gated data clock |
| word_o | output | RES_BITS | Collected result word |
| chan_o | output | max(1, clog2(N_DEV*CH_PER_DEV)) | Index of the word in the chain |
| word_valid_o | output | 1 | One-cycle strobe for `word_o`/`chan_o` |
| overrun_o | output | 1 | Sticky flag: new data-ready during a readout |

## Verification
The bench builds the controller with two devices, two channels each and 8-bit results, so one readout is 32 bits in four words. It uses a data-clock divider of 2, a 200-cycle conversion half period, a guard of 4 cycles and a 10-cycle reset pulse. A readout of about 130 cycles then fits inside one conversion half period or crosses a toggle, depending on when the bench raises the ready edge. This lets the pause at a bit boundary be exercised deliberately, next to readouts that run without a pause. The short reset pulse and the small chain also keep the repeated discard sequence and a reset during a shift within a few thousand cycles.

// File: rtl/adc_chain_reader.sv
module adc_chain_reader #(
  parameter int N_DEV      = 1,
  parameter int CH_PER_DEV = 32,
  parameter int RES_BITS   = 20,
  parameter int DCLK_DIV   = 2,
  parameter int CONV_CYC   = 4096,
  parameter int CONV_GUARD = 4,
  parameter int RST_CYC    = 1000,
  parameter int SKIP_CONV  = 4,
  localparam int WORDS     = N_DEV * CH_PER_DEV,
  localparam int WCW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dready_n_i,
  input  logic                sdata_i,
  output logic                conv_o,
  output logic                dev_rst_n_o,
  output logic                dclk_o,
  output logic [RES_BITS-1:0] word_o,
  output logic [WCW-1:0]      chan_o,
  output logic                word_valid_o,
  output logic                overrun_o
);
  localparam int TOTAL = WORDS * RES_BITS;
  localparam int BCW   = $clog2(TOTAL + 1);
  localparam int RCW   = $clog2(RST_CYC + 1);
  localparam int CCW   = $clog2(CONV_CYC);
  localparam int DVW   = $clog2(DCLK_DIV + 1);
  localparam int SKW   = $clog2(SKIP_CONV + 1);
  localparam int BWW   = $clog2(RES_BITS);
  localparam int RISE_LIM = CONV_CYC - DCLK_DIV - CONV_GUARD;

  logic [RCW-1:0] rst_cnt;
  logic           dev_rel_q;
  logic [CCW-1:0] conv_cnt;
  logic           conv_q;
  logic [2:0]     dr_sync;
  logic [SKW-1:0] skip_cnt;
  logic           busy;
  logic           dclk_q;
  logic [DVW-1:0] div_cnt;
  logic [BCW-1:0] bit_cnt;
  logic [BWW-1:0] wbit;
  logic [WCW-1:0] widx;
  logic [RES_BITS-1:0] sh;
  logic           dr_fall, can_rise, div_end;

  assign dev_rst_n_o = dev_rel_q;
  assign conv_o      = conv_q;
  assign dclk_o      = dclk_q;
  assign dr_fall     = dr_sync[2] & ~dr_sync[1];
  assign div_end     = (div_cnt == DVW'(DCLK_DIV - 1));
  assign can_rise    = (conv_cnt >= CCW'(CONV_GUARD)) && (conv_cnt < CCW'(RISE_LIM));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_cnt   <= '0;
      dev_rel_q <= 1'b0;
    end else if (!dev_rel_q) begin
      rst_cnt   <= rst_cnt + 1'b1;
      dev_rel_q <= (rst_cnt == RCW'(RST_CYC - 1));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      conv_cnt <= '0;
      conv_q   <= 1'b0;
    end else if (dev_rel_q) begin
      if (conv_cnt == CCW'(CONV_CYC - 1)) begin
        conv_cnt <= '0;
        conv_q   <= ~conv_q;
      end else begin
        conv_cnt <= conv_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dr_sync <= 3'b111;
    else        dr_sync <= {dr_sync[1:0], dready_n_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      skip_cnt     <= '0;
      busy         <= 1'b0;
      dclk_q       <= 1'b0;
      div_cnt      <= '0;
      bit_cnt      <= '0;
      wbit         <= '0;
      widx         <= '0;
      sh           <= '0;
      word_o       <= '0;
      chan_o       <= '0;
      word_valid_o <= 1'b0;
      overrun_o    <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      if (dr_fall && dev_rel_q) begin
        if (busy)
          overrun_o <= 1'b1;
        else if (skip_cnt != SKW'(SKIP_CONV))
          skip_cnt <= skip_cnt + 1'b1;
        else begin
          busy    <= 1'b1;
          div_cnt <= '0;
          bit_cnt <= '0;
          wbit    <= '0;
          widx    <= '0;
        end
      end
      if (busy) begin
        if (dclk_q) begin
          if (div_end) begin
            dclk_q  <= 1'b0;
            div_cnt <= '0;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end else if (!div_end) begin
          div_cnt <= div_cnt + 1'b1;
        end else if (bit_cnt == BCW'(TOTAL)) begin
          busy <= 1'b0;
        end else if (can_rise) begin
          dclk_q  <= 1'b1;
          div_cnt <= '0;
          bit_cnt <= bit_cnt + 1'b1;
          sh      <= {sh[RES_BITS-2:0], sdata_i};
          if (wbit == BWW'(RES_BITS - 1)) begin
            wbit         <= '0;
            word_o       <= {sh[RES_BITS-2:0], sdata_i};
            chan_o       <= widx;
            word_valid_o <= 1'b1;
            widx         <= widx + 1'b1;
          end else begin
            wbit <= wbit + 1'b1;
          end
        end
      end
    end
endmodule

module adc_chain_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_o,
  input logic dclk_o,
  input logic dev_rst_n_o,
  input logic word_valid_o,
  input logic overrun_o
);
  AST_ONE_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $past(dev_rst_n_o) |-> dev_rst_n_o); // R1
  AST_CONV_HELD: assert property (@(posedge clk) disable iff (!rst_n) !dev_rst_n_o |-> !conv_o); // R2
  AST_QUIET_IN_DEVRST: assert property (@(posedge clk) disable iff (!rst_n) !dev_rst_n_o |-> (!dclk_o && !word_valid_o)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) word_valid_o |=> !word_valid_o); // R5
  AST_DCLK_LOW_AT_CONV: assert property (@(posedge clk) disable iff (!rst_n) (conv_o != $past(conv_o)) |-> (!dclk_o && !$past(dclk_o))); // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(overrun_o) |-> overrun_o); // R7
endmodule

bind adc_chain_reader adc_chain_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_o(conv_o), .dclk_o(dclk_o),
  .dev_rst_n_o(dev_rst_n_o), .word_valid_o(word_valid_o), .overrun_o(overrun_o)
);

// File: tb/test_adc_chain_reader.sv
`timescale 1ns/1ps
module test_adc_chain_reader;
  localparam int N_DEV = 2, CH = 2, BITS = 8, DIV = 2;
  localparam int CONV_CYC = 200, GUARD = 4, RST_CYC = 10, SKIP = 4;
  localparam int WORDS = N_DEV * CH;
  localparam int TOTAL = WORDS * BITS;
  localparam int WCW = $clog2(WORDS);

  logic clk = 1'b0, rst_n = 1'b0, dready_n = 1'b1, sdata;
  logic conv_o, dev_rst_n_o, dclk_o, word_valid_o, overrun_o;
  logic [BITS-1:0] word_o;
  logic [WCW-1:0]  chan_o;

  always #2 clk = ~clk;

  adc_chain_reader #(.N_DEV(N_DEV), .CH_PER_DEV(CH), .RES_BITS(BITS), .DCLK_DIV(DIV),
    .CONV_CYC(CONV_CYC), .CONV_GUARD(GUARD), .RST_CYC(RST_CYC), .SKIP_CONV(SKIP)) i_adc_chain_reader (
    .clk(clk), .rst_n(rst_n), .dready_n_i(dready_n), .sdata_i(sdata), .conv_o(conv_o),
    .dev_rst_n_o(dev_rst_n_o), .dclk_o(dclk_o), .word_o(word_o), .chan_o(chan_o),
    .word_valid_o(word_valid_o), .overrun_o(overrun_o));

  int nchk = 0, nerr = 0;
  logic [TOTAL-1:0] frame = '0;
  int ptr = 0, rises = 0, nw = 0;
  logic [BITS-1:0] got_w [WORDS];
  int got_c [WORDS];
  int conv_viol = 0, guard_viol = 0, hi_err = 0, hi_run = 0, since_tog = 1000;
  logic conv_prev = 1'b0, dclk_prev = 1'b0;

  assign sdata = (ptr < TOTAL) ? frame[TOTAL-1-ptr] : 1'b0;
  always @(negedge dclk_o) ptr++;
  always @(posedge dclk_o) rises++;

  always @(negedge clk) begin
    if (word_valid_o && nw < WORDS) begin
      got_w[nw] = word_o;
      got_c[nw] = int'(chan_o);
      nw++;
    end
    if (rst_n) begin
      if (conv_o != conv_prev) begin
        if (dclk_o || dclk_prev) conv_viol++;
        since_tog = 0;
      end else if (since_tog < 1000) since_tog++;
      if (dclk_o && !dclk_prev && since_tog <= GUARD) guard_viol++;
      if (dclk_o) hi_run++;
      else if (hi_run != 0) begin
        if (hi_run != DIV) hi_err++;
        hi_run = 0;
      end
    end
    conv_prev = conv_o;
    dclk_prev = dclk_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_toggle();
    logic c = conv_o;
    while (conv_o == c) @(negedge clk);
  endtask

  task automatic pulse_ready();
    @(negedge clk) dready_n = 1'b0;
    repeat (3) @(negedge clk);
    dready_n = 1'b1;
  endtask

  task automatic t_reset_state();
    #1;
    check(!dev_rst_n_o && !conv_o && !dclk_o && !word_valid_o && !overrun_o, "R9 reset state",
          {dev_rst_n_o, conv_o, dclk_o, word_valid_o, overrun_o}, 0);
  endtask

  task automatic t_dev_reset();
    int n = 0;
    @(negedge clk) rst_n = 1'b1;
    while (!dev_rst_n_o && n < 5000) begin @(posedge clk); @(negedge clk); n++; end
    check(n == RST_CYC, "R1 device reset width", n, RST_CYC);
    repeat (30) @(negedge clk);
    check(dev_rst_n_o, "R1 reset stays released", dev_rst_n_o, 1);
  endtask

  task automatic t_conv_period();
    int n;
    wait_toggle();
    for (int k = 0; k < 2; k++) begin
      n = 0;
      begin
        logic c = conv_o;
        while (conv_o == c && n < 5000) begin @(negedge clk); n++; end
      end
      check(n == CONV_CYC, "R2 conversion toggle interval", n, CONV_CYC);
    end
  endtask

  task automatic t_discard();
    rises = 0; nw = 0;
    for (int k = 0; k < SKIP; k++) begin
      wait_toggle();
      repeat (10) @(negedge clk);
      pulse_ready();
      repeat (150) @(negedge clk);
    end
    check(rises == 0, "R3 ignored ready edges make no dclk", rises, 0);
    check(nw == 0, "R3 ignored ready edges make no word", nw, 0);
  endtask

  task automatic collect(input logic [TOTAL-1:0] f, input string tag);
    int n = 0;
    while (nw < WORDS && n < 3000) begin @(negedge clk); n++; end
    repeat (12) @(negedge clk);
    check(nw == WORDS, {"R5 word count ", tag}, nw, WORDS);
    for (int k = 0; k < WORDS; k++) begin
      check(got_w[k] == f[TOTAL-1-k*BITS -: BITS], {"R5 word value ", tag}, got_w[k], f[TOTAL-1-k*BITS -: BITS]);
      check(got_c[k] == k, {"R5 channel index ", tag}, got_c[k], k);
    end
    check(rises == TOTAL, {"R4 dclk edge count ", tag}, rises, TOTAL);
    check(!dclk_o, {"R4 dclk parked low ", tag}, dclk_o, 0);
  endtask

  task automatic t_readout(input logic [TOTAL-1:0] f, input int delay, input string tag);
    wait_toggle();
    repeat (delay) @(negedge clk);
    frame = f; ptr = 0; nw = 0; rises = 0;
    pulse_ready();
    collect(f, tag);
  endtask

  task automatic t_overrun();
    check(!overrun_o, "R7 overrun clear before", overrun_o, 0);
    wait_toggle();
    repeat (10) @(negedge clk);
    frame = 32'h3C96_E1A7; ptr = 0; nw = 0; rises = 0;
    pulse_ready();
    repeat (30) @(negedge clk);
    pulse_ready();
    collect(32'h3C96_E1A7, "overrun");
    check(overrun_o, "R7 overrun set", overrun_o, 1);
    repeat (300) @(negedge clk);
    check(overrun_o, "R7 overrun sticky", overrun_o, 1);
  endtask

  task automatic t_async_reset();
    wait_toggle();
    frame = 32'hFFFF_0000; ptr = 0; nw = 0; rises = 0;
    pulse_ready();
    repeat (40) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(!dclk_o && !conv_o && !word_valid_o && !overrun_o && !dev_rst_n_o, "R9 async reset mid-readout",
          {dclk_o, conv_o, word_valid_o, overrun_o, dev_rst_n_o}, 0);
    repeat (3) @(negedge clk);
    t_dev_reset();
    t_discard();
    t_readout(32'h0F1E_2D3C, 20, "after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_dev_reset();
    t_conv_period();
    t_discard();
    t_readout(32'hA5C3_0F81, 10, "no pause");
    t_readout(32'hFFFF_FFFF, 20, "all ones");
    t_readout(32'h1234_5678, 150, "crosses toggle");
    t_readout(32'h0000_0000, 120, "zeros crossing");
    t_overrun();
    t_async_reset();
    check(conv_viol == 0, "R6 dclk low around conv change", conv_viol, 0);
    check(guard_viol == 0, "R6 no rise inside guard", guard_viol, 0);
    check(hi_err == 0, "R8 dclk high phase width", hi_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule